// File: doc/BRIEF.md
# Processor Idle State Sequencer

This block sits on the chipset side of a small multiprocessor system and moves each processor between running and three idle levels, C1, C2 and C3. Each processor has its own pair of level-command registers. A read of the first register asks for C2 and a read of the second asks for C3. A read returns zero. The sequencer then raises a stop-clock request to that processor and reports the idle level once the processor acknowledges the request. C1 needs no handshake: the processor enters it with its own halt instruction, and the sequencer only follows the halt indication.

A pending interrupt, or a wake event that is enabled in the per-processor wake mask, brings a processor in C2 or C3 back to running. To do this the sequencer drops the stop-clock request and waits for the acknowledge to fall. Snoop traffic from bus masters or other processors is granted in C2 without waking the processor. In C3 snoop traffic is held off. Each processor advertises a capability mask. If the masks are not all equal, every processor is limited to C1. If they are equal, a command for a level that is missing from the shared mask is ignored.

Top module: `idle_seq_top`

## Requirements
- R1: The command reads, halt, wake, snoop and acknowledge inputs of one processor change only that processor's status, stop-clock request and snoop grant.
- R2: A level-2 read while running and while C2 is permitted raises the stop-clock request in the next cycle, with status 4 (transitioning). The status becomes 2 (C2) in the cycle after the acknowledge is seen high.
- R3: A level-3 read while running and while C3 is permitted works the same way and ends in status 3 (C3).
- R4: While running, a high halt input gives status 1 (C1) in the next cycle with no stop-clock request. A low halt then returns the status to 0 (running) in the next cycle.
- R5: In C2 or C3, a pending interrupt, or a wake event whose wake-enable bit is set, gives status 4 with the request low in the next cycle. A wake event whose enable bit is clear has no effect.
- R6: The status reaches 2 or 3 only after the acknowledge was high. It returns to 0 from an exit only after the acknowledge was low.
- R7: In C2, snoop traffic does not change the state, and snoop_ok follows snoop_req. In C3, snoop_ok stays low.
- R8: Each processor's capability mask uses bit 0 for C1, bit 1 for C2 and bit 2 for C3. If any two masks differ, every level-2 and level-3 read is ignored and the processor stays running. If all masks are equal, a read for a level whose bit is clear in the mask is ignored.
- R9: A command read while the processor is not running (in C1, idle or transitioning) is dropped, and the original target level is kept.
- R10: A wake during entry, before the acknowledge, aborts the entry. The request drops and the processor returns to running once the acknowledge is low.
- R11: The command read data is always zero.
- R12: The 3-bit status per processor encodes 0 as running, 1 as C1, 2 as C2, 3 as C3 and 4 as transitioning. Reset gives running with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_mask | input | N_CPU*3 | Per-processor capability mask (bit 0 C1, bit 1 C2, bit 2 C3) |
| rd_lvl2 | input | N_CPU | Read strobe of each processor's level-2 command register |
| rd_lvl3 | input | N_CPU | Read strobe of each processor's level-3 command register |
| halt | input | N_CPU | Halt indication from each processor |
| irq_pend | input | N_CPU | Pending interrupt per processor |
| wake_evt | input | N_CPU | Other wake source per processor |
| wake_en | input | N_CPU | Wake-mask enable for wake_evt |
| snoop_req | input | N_CPU | Snoop traffic aimed at each processor |
| stpclk_ack | input | N_CPU | Stop-clock acknowledge from each processor |
| stpclk_req | output | N_CPU | Stop-clock request to each processor |
| snoop_ok | output | N_CPU | Snoop grant per processor |
| state_code | output | N_CPU*3 | Per-processor 3-bit status |
| cmd_rdata | output | RDATA_W | Read data of the command registers (zero) |

## Verification
The assertions assume that a processor answers the stop-clock handshake in order. The acknowledge rises only while the request is high and falls only after the request has dropped. They also assume that the capability masks stay stable while a command is in flight. The bench keeps to these rules. It holds every acknowledge low until a request is seen and releases it only after an exit has started, and it changes the capability masks only while every processor is running. Inputs change away from the clock edge and are held for whole cycles, so every strobe lasts exactly one sampled cycle.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_C1    = 3'd1,
        ST_ENTER = 3'd2,
        ST_IN2   = 3'd3,
        ST_IN3   = 3'd4,
        ST_EXIT  = 3'd5
    } seq_state_e;

    localparam logic [2:0] CODE_RUN   = 3'd0;
    localparam logic [2:0] CODE_C1    = 3'd1;
    localparam logic [2:0] CODE_C2    = 3'd2;
    localparam logic [2:0] CODE_C3    = 3'd3;
    localparam logic [2:0] CODE_TRANS = 3'd4;

    localparam int CAP_W = 3;

    typedef struct packed {
        logic allow_c2;
        logic allow_c3;
    } permit_t;

    function automatic logic [2:0] state_to_code(input seq_state_e s);
        case (s)
            ST_RUN:  return CODE_RUN;
            ST_C1:   return CODE_C1;
            ST_IN2:  return CODE_C2;
            ST_IN3:  return CODE_C3;
            default: return CODE_TRANS;
        endcase
    endfunction

endpackage

// File: rtl/cap_reduce.sv
module cap_reduce
    import idle_seq_pkg::*;
#(
    parameter int N_CPU = 2
) (
    input  logic [N_CPU*CAP_W-1:0] cap_mask,
    output permit_t                permit
);
    logic [N_CPU-1:0] same;

    generate
        for (genvar i = 0; i < N_CPU; i++) begin : g_cmp
            assign same[i] = (cap_mask[i*CAP_W +: CAP_W] == cap_mask[0 +: CAP_W]);
        end
    endgenerate

    always_comb begin
        permit.allow_c2 = (&same) & cap_mask[1];
        permit.allow_c3 = (&same) & cap_mask[2];
    end
endmodule

// File: rtl/cpu_idle_fsm.sv
module cpu_idle_fsm
    import idle_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  permit_t    permit,
    input  logic       rd_lvl2,
    input  logic       rd_lvl3,
    input  logic       halt,
    input  logic       irq_pend,
    input  logic       wake_evt,
    input  logic       wake_en,
    input  logic       snoop_req,
    input  logic       stpclk_ack,
    output logic       stpclk_req,
    output logic       snoop_ok,
    output logic [2:0] code
);
    seq_state_e st, st_nx;
    logic       tgt_c3, tgt_c3_nx;
    logic       wake;
    logic       want2, want3;

    assign wake  = irq_pend | (wake_evt & wake_en);
    assign want2 = rd_lvl2 & permit.allow_c2;
    assign want3 = rd_lvl3 & permit.allow_c3;

    always_comb begin
        st_nx     = st;
        tgt_c3_nx = tgt_c3;
        case (st)
            ST_RUN: begin
                if (halt) begin
                    st_nx = ST_C1;
                end else if (want3) begin
                    st_nx     = ST_ENTER;
                    tgt_c3_nx = 1'b1;
                end else if (want2) begin
                    st_nx     = ST_ENTER;
                    tgt_c3_nx = 1'b0;
                end
            end
            ST_C1:    if (!halt) st_nx = ST_RUN;
            ST_ENTER: begin
                if (wake)            st_nx = ST_EXIT;
                else if (stpclk_ack) st_nx = tgt_c3 ? ST_IN3 : ST_IN2;
            end
            ST_IN2, ST_IN3: if (wake) st_nx = ST_EXIT;
            ST_EXIT:  if (!stpclk_ack) st_nx = ST_RUN;
            default:  st_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_RUN;
            tgt_c3 <= 1'b0;
        end else begin
            st     <= st_nx;
            tgt_c3 <= tgt_c3_nx;
        end
    end

    assign stpclk_req = (st == ST_ENTER) || (st == ST_IN2) || (st == ST_IN3);
    assign snoop_ok   = snoop_req && (st != ST_IN3);
    assign code       = state_to_code(st);

    logic deep;
    assign deep = (st == ST_IN2) || (st == ST_IN3);

    AST_ENTRY_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        (deep && $past(st) == ST_ENTER) |-> $past(stpclk_ack)); // R6
    AST_RUN_AFTER_ACK_LOW: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && $past(st) == ST_EXIT) |-> !$past(stpclk_ack)); // R6
    AST_WAKE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (rst)
        (deep && wake) |=> (code == CODE_TRANS && !stpclk_req)); // R5
    AST_SNOOP_KEEPS_C2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IN2 && snoop_req && !wake) |=> st == ST_IN2); // R7
    AST_DENIED_STAYS_RUN: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && !halt && !permit.allow_c2 && !permit.allow_c3) |=> st == ST_RUN); // R8
    AST_BUSY_DROPS_CMD: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ENTER && !wake && !stpclk_ack) |=> (st == ST_ENTER && $stable(tgt_c3))); // R9
    AST_ABORT_ON_WAKE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ENTER && wake) |=> st == ST_EXIT); // R10
endmodule

// File: rtl/idle_seq_top.sv
module idle_seq_top
    import idle_seq_pkg::*;
#(
    parameter int N_CPU   = 2,
    parameter int RDATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_CPU*CAP_W-1:0] cap_mask,
    input  logic [N_CPU-1:0]       rd_lvl2,
    input  logic [N_CPU-1:0]       rd_lvl3,
    input  logic [N_CPU-1:0]       halt,
    input  logic [N_CPU-1:0]       irq_pend,
    input  logic [N_CPU-1:0]       wake_evt,
    input  logic [N_CPU-1:0]       wake_en,
    input  logic [N_CPU-1:0]       snoop_req,
    input  logic [N_CPU-1:0]       stpclk_ack,
    output logic [N_CPU-1:0]       stpclk_req,
    output logic [N_CPU-1:0]       snoop_ok,
    output logic [N_CPU*3-1:0]     state_code,
    output logic [RDATA_W-1:0]     cmd_rdata
);
    permit_t permit;

    cap_reduce #(.N_CPU(N_CPU)) u_cap (
        .cap_mask (cap_mask),
        .permit   (permit)
    );

    generate
        for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
            cpu_idle_fsm u_fsm (
                .clk        (clk),
                .rst        (rst),
                .permit     (permit),
                .rd_lvl2    (rd_lvl2[i]),
                .rd_lvl3    (rd_lvl3[i]),
                .halt       (halt[i]),
                .irq_pend   (irq_pend[i]),
                .wake_evt   (wake_evt[i]),
                .wake_en    (wake_en[i]),
                .snoop_req  (snoop_req[i]),
                .stpclk_ack (stpclk_ack[i]),
                .stpclk_req (stpclk_req[i]),
                .snoop_ok   (snoop_ok[i]),
                .code       (state_code[i*3 +: 3])
            );
        end
    endgenerate

    assign cmd_rdata = '0;
endmodule

// File: tb/idle_seq_top_test.sv
module idle_seq_top_test;
    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst;
    logic [N*3-1:0] cap_mask;
    logic [N-1:0] rd_lvl2, rd_lvl3, halt, irq_pend, wake_evt, wake_en, snoop_req, stpclk_ack;
    logic [N-1:0] stpclk_req, snoop_ok;
    logic [N*3-1:0] state_code;
    logic [7:0]   cmd_rdata;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    idle_seq_top #(.N_CPU(N), .RDATA_W(8)) uut (
        .clk(clk), .rst(rst), .cap_mask(cap_mask), .rd_lvl2(rd_lvl2), .rd_lvl3(rd_lvl3),
        .halt(halt), .irq_pend(irq_pend), .wake_evt(wake_evt), .wake_en(wake_en),
        .snoop_req(snoop_req), .stpclk_ack(stpclk_ack), .stpclk_req(stpclk_req),
        .snoop_ok(snoop_ok), .state_code(state_code), .cmd_rdata(cmd_rdata)
    );

    // Row layout: [10]rd2 [9]rd3 [8]halt [7]irq [6]ack [5]snoop | [4:2]status [1]req [0]snoop_ok
    localparam int NV = 23;
    localparam logic [10:0] VEC [0:NV-1] = '{
        11'b000000_000_0_0, // idle running (R12)
        11'b100000_100_1_0, // lvl2 read -> entering (R2)
        11'b000000_100_1_0, // waiting for ack (R6)
        11'b000010_010_1_0, // ack -> C2 (R2)
        11'b000011_010_1_1, // snoop in C2 stays, granted (R7)
        11'b000110_100_0_0, // irq -> exit (R5)
        11'b000000_000_0_0, // ack low -> running (R6)
        11'b010000_100_1_0, // lvl3 read (R3)
        11'b000010_011_1_0, // ack -> C3 (R3)
        11'b000011_011_1_0, // snoop in C3 held off (R7)
        11'b000110_100_0_0, // irq -> exit (R5)
        11'b000000_000_0_0, // running
        11'b100000_100_1_0, // lvl2 read
        11'b000100_100_0_0, // irq before ack aborts (R10)
        11'b000000_000_0_0, // back to running (R10)
        11'b001000_001_0_0, // halt -> C1 (R4)
        11'b101000_001_0_0, // lvl2 while in C1 dropped (R9)
        11'b000000_000_0_0, // halt low -> running (R4)
        11'b100000_100_1_0, // lvl2 read
        11'b010000_100_1_0, // lvl3 during entry dropped (R9)
        11'b000010_010_1_0, // ends in C2, target kept (R9)
        11'b000110_100_0_0, // exit
        11'b000000_000_0_0  // running
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_in;
        rd_lvl2 = '0; rd_lvl3 = '0; halt = '0; irq_pend = '0;
        wake_evt = '0; wake_en = '0; snoop_req = '0;
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; cap_mask = {3'b111, 3'b111}; stpclk_ack = '0; clear_in();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        check("R12 reset status", {2'b0, state_code}, 8'h00);
        check("R12 reset req", {6'b0, stpclk_req}, 8'h00);
        check("R11 read data zero", cmd_rdata, 8'h00);

        // Vector walk on processor 0
        for (int v = 0; v < NV; v++) begin
            clear_in();
            rd_lvl2[0]    = VEC[v][10];
            rd_lvl3[0]    = VEC[v][9];
            halt[0]       = VEC[v][8];
            irq_pend[0]   = VEC[v][7];
            stpclk_ack[0] = VEC[v][6];
            snoop_req[0]  = VEC[v][5];
            tick();
            check($sformatf("R2/R3/R4/R5/R6/R7/R9/R10 vec%0d status", v), {5'b0, state_code[2:0]}, {5'b0, VEC[v][4:2]});
            check($sformatf("R6 vec%0d req", v), {7'b0, stpclk_req[0]}, {7'b0, VEC[v][1]});
            check($sformatf("R7 vec%0d snoop_ok", v), {7'b0, snoop_ok[0]}, {7'b0, VEC[v][0]});
            // R1: processor 1 untouched
            check($sformatf("R1 vec%0d other cpu", v), {5'b0, state_code[5:3]}, 8'h00);
        end
        clear_in(); stpclk_ack = '0; tick();

        // R1: command to processor 1 only
        rd_lvl2[1] = 1'b1; tick(); clear_in();
        check("R1 cpu1 entering", {5'b0, state_code[5:3]}, 8'h04);
        check("R1 cpu0 still running", {5'b0, state_code[2:0]}, 8'h00);
        stpclk_ack[1] = 1'b1; tick();
        check("R1 cpu1 C2", {5'b0, state_code[5:3]}, 8'h02);
        // R5: wake event masked off has no effect
        wake_evt[1] = 1'b1; tick();
        check("R5 masked wake ignored", {5'b0, state_code[5:3]}, 8'h02);
        wake_en[1] = 1'b1; tick(); clear_in();
        check("R5 enabled wake exits", {6'b0, state_code[5:3] == 3'd4, stpclk_req[1]}, 8'h02);
        stpclk_ack[1] = 1'b0; tick();
        check("R5 cpu1 running", {5'b0, state_code[5:3]}, 8'h00);

        // R8: masks differ -> all deep commands ignored
        cap_mask = {3'b001, 3'b111};
        rd_lvl2[0] = 1'b1; tick(); clear_in();
        check("R8 mismatch lvl2 ignored", {5'b0, state_code[2:0]}, 8'h00);
        rd_lvl3[0] = 1'b1; tick(); clear_in();
        check("R8 mismatch lvl3 ignored", {6'b0, stpclk_req}, 8'h00);
        // R8: equal masks without C3
        cap_mask = {3'b011, 3'b011};
        rd_lvl3[0] = 1'b1; tick(); clear_in();
        check("R8 C3 unsupported ignored", {5'b0, state_code[2:0]}, 8'h00);
        rd_lvl2[0] = 1'b1; tick(); clear_in();
        check("R8 C2 supported accepted", {5'b0, state_code[2:0]}, 8'h04);
        irq_pend[0] = 1'b1; tick(); clear_in(); tick();
        check("R10 abort returns to running", {5'b0, state_code[2:0]}, 8'h00);
        check("R11 read data zero after use", cmd_rdata, 8'h00);

        // R12: reset mid-idle returns to running
        cap_mask = {3'b111, 3'b111};
        rd_lvl3[0] = 1'b1; tick(); clear_in();
        rst = 1'b1; tick(); rst = 1'b0;
        check("R12 reset clears entry", {2'b0, state_code}, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule